// File: doc/BRIEF.md
# Six-Channel Load Fault Supervisor

This block sits between the gate commands of a six-output low-side driver and the gate pins. Each channel takes a gate-on request and a digitised drain comparator bit, where a high bit means the drain voltage is above the fault threshold. The block decides whether the gate really turns on. A channel whose drain stays high while the gate is on is treated as a shorted load. Its gate is forced off for a long refresh interval and then retried, so a persistent short runs at a very low on duty cycle. A channel whose drain stays low while the gate is commanded off is reported as an open load.

Two supply conditions, power-on reset and supply overvoltage, are active-high inputs. Either one forces every gate low. Each channel keeps sticky short and open flags. A one-cycle read strobe copies all twelve flags to the outputs and clears them. All timing is counted in system clock cycles.

Top module: `lsd_fault_supervisor`

## Requirements
- R1: After synchronous reset, every gate_en bit, every short_flags bit and every open_flags bit is 0.
- R2: With no fault and no supply condition, gate_en[i] rises on the first clock edge that samples gate_cmd[i] high. It falls on the first edge that samples gate_cmd[i] low.
- R3: When por_active or ovp_active is sampled high, every gate_en bit is 0 from that edge on, for as long as the condition lasts. No short or open fault is sensed while it lasts. When it clears, a channel whose command is still high turns on at the next edge.
- R4: While gate_en[i] is 1 and gate_cmd[i] is 1, drain_hi[i] high on SENSE_CYC consecutive sampled cycles turns gate_en[i] off at the SENSE_CYC-th edge and records a short. A high run that is shorter does neither, and the run count restarts whenever drain_hi[i] is sampled low.
- R5: After a short trip, gate_en[i] stays 0 for exactly REFRESH_CYC cycles. It then turns on again if gate_cmd[i] is high. Under a persistent short the gate is on for SENSE_CYC cycles out of every SENSE_CYC+REFRESH_CYC.
- R6: A gate_cmd[i] that goes low and then high again during the refresh interval does not reach gate_en[i] before the interval ends. A command that is low at the end of the interval leaves the channel idle with its gate off.
- R7: While gate_en[i] is 0, gate_cmd[i] is 0 and no supply condition is active, drain_hi[i] low on OPEN_CYC consecutive sampled cycles records an open load. A shorter low run does not record one.
- R8: On the edge that samples status_rd high, short_flags and open_flags load the sticky flags, together with any fault recorded on that same edge, and the sticky flags clear. Bit i belongs to channel i. A short flag stays latched after the command is removed until it is read. A fault that is still present sets its flag again.
- R9: The channels are independent. A fault, a timer or a refresh on one channel does not change the gate or the flags of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_active | input | 1 | Supply power-on-reset condition; forces all gates low |
| ovp_active | input | 1 | Supply overvoltage shutdown; forces all gates low |
| gate_cmd | input | NCH | Per-channel gate-on request |
| drain_hi | input | NCH | Per-channel drain comparator bit; 1 means above threshold |
| status_rd | input | 1 | One-cycle strobe that captures and clears the flags |
| gate_en | output | NCH | Registered gate enable for each channel |
| short_flags | output | NCH | Captured short-load flags, bit i for channel i |
| open_flags | output | NCH | Captured open-load flags, bit i for channel i |

## Verification
The bench steps an independent cycle model of every channel and compares the gate outputs to it on every cycle. A stuck or miscounted sense timer shows as a gate that turns off one edge early or late, in the very cycle of the mistake. A wrong refresh count shows as a retry edge REFRESH_CYC cycles after a trip that lands in the wrong place. Errors in the sticky flags or the open-load timer stay hidden until the next read strobe, so the bench reads often and also reads at once after each directed fault.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    CH_IDLE    = 2'd0,
    CH_ON      = 2'd1,
    CH_REFRESH = 2'd2
  } ch_state_e;
endpackage

// File: rtl/lfs_run_timer.sv
// Counts consecutive sampled cycles of cond; hit marks the LEN-th one.
module lfs_run_timer #(
  parameter int LEN = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic hit
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign hit = cond && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lfs_channel.sv
module lfs_channel
  import lfs_pkg::*;
#(
  parameter int SENSE_CYC   = 28,
  parameter int REFRESH_CYC = 1000,
  parameter int OPEN_CYC    = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic gate_cmd,
  input  logic drain_hi,
  output logic gate_q,
  output logic short_hit,
  output logic open_hit
);
  localparam int RW = $clog2(REFRESH_CYC + 1);
  localparam logic [RW-1:0] R_LAST = RW'(REFRESH_CYC - 1);

  ch_state_e state, nxt;
  logic [RW-1:0] rcnt;
  logic short_cond, open_cond;

  assign short_cond = !kill && (state == CH_ON) && gate_cmd && drain_hi;
  assign open_cond  = !kill && !gate_q && !gate_cmd && !drain_hi;

  lfs_run_timer #(.LEN(SENSE_CYC)) u_short_tmr (
    .clk(clk), .rst(rst), .cond(short_cond), .hit(short_hit)
  );

  lfs_run_timer #(.LEN(OPEN_CYC)) u_open_tmr (
    .clk(clk), .rst(rst), .cond(open_cond), .hit(open_hit)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      CH_IDLE:    if (gate_cmd) nxt = CH_ON;
      CH_ON: begin
        if (!gate_cmd)      nxt = CH_IDLE;
        else if (short_hit) nxt = CH_REFRESH;
      end
      CH_REFRESH: if (rcnt == R_LAST) nxt = gate_cmd ? CH_ON : CH_IDLE;
      default:    nxt = CH_IDLE;
    endcase
    if (kill) nxt = CH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CH_IDLE;
      gate_q <= 1'b0;
      rcnt   <= '0;
    end else begin
      state  <= nxt;
      gate_q <= (nxt == CH_ON);
      rcnt   <= (state == CH_REFRESH && nxt == CH_REFRESH) ? rcnt + 1'b1 : '0;
    end
  end

  // R3
  kill_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> !gate_q);
  // R4
  short_trip_chk: assert property (@(posedge clk) disable iff (rst)
    short_hit |=> (!gate_q && state == CH_REFRESH));
  // R6
  refresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == CH_REFRESH && rcnt != R_LAST) |=> !gate_q);
  // R7
  open_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    open_hit |-> (!gate_q && !gate_cmd && !kill));
  // R2
  gate_rise_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(gate_cmd));
endmodule

// File: rtl/lfs_flag_bank.sv
module lfs_flag_bank #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           status_rd,
  input  logic [NCH-1:0] short_evt,
  input  logic [NCH-1:0] open_evt,
  output logic [NCH-1:0] short_cap,
  output logic [NCH-1:0] open_cap
);
  logic [NCH-1:0] st_short, st_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_short  <= '0;
      st_open   <= '0;
      short_cap <= '0;
      open_cap  <= '0;
    end else if (status_rd) begin
      short_cap <= st_short | short_evt;
      open_cap  <= st_open | open_evt;
      st_short  <= '0;
      st_open   <= '0;
    end else begin
      st_short  <= st_short | short_evt;
      st_open   <= st_open | open_evt;
    end
  end

  // R8
  short_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!status_rd && |short_evt) |=> ((st_short & $past(short_evt)) == $past(short_evt)));
  // R8
  cap_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !status_rd |=> ($stable(short_cap) && $stable(open_cap)));
endmodule

// File: rtl/lsd_fault_supervisor.sv
module lsd_fault_supervisor #(
  parameter int NCH         = 6,
  parameter int SENSE_CYC   = 28,
  parameter int REFRESH_CYC = 1000,
  parameter int OPEN_CYC    = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           por_active,
  input  logic           ovp_active,
  input  logic [NCH-1:0] gate_cmd,
  input  logic [NCH-1:0] drain_hi,
  input  logic           status_rd,
  output logic [NCH-1:0] gate_en,
  output logic [NCH-1:0] short_flags,
  output logic [NCH-1:0] open_flags
);
  logic           kill;
  logic [NCH-1:0] short_evt, open_evt;

  assign kill = por_active | ovp_active;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    lfs_channel #(
      .SENSE_CYC  (SENSE_CYC),
      .REFRESH_CYC(REFRESH_CYC),
      .OPEN_CYC   (OPEN_CYC)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .kill     (kill),
      .gate_cmd (gate_cmd[i]),
      .drain_hi (drain_hi[i]),
      .gate_q   (gate_en[i]),
      .short_hit(short_evt[i]),
      .open_hit (open_evt[i])
    );
  end

  lfs_flag_bank #(.NCH(NCH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .status_rd(status_rd),
    .short_evt(short_evt),
    .open_evt (open_evt),
    .short_cap(short_flags),
    .open_cap (open_flags)
  );

  // R3
  all_gates_kill_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> (gate_en == '0));
  // R9
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    ((short_evt & open_evt) == '0));
endmodule

// File: tb/tb_lsd_fault_supervisor.sv
module tb_lsd_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int S = 4;
  localparam int R = 20;
  localparam int O = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por = 1'b0, ovp = 1'b0, rd = 1'b0;
  logic [NCH-1:0] cmd = '0, drn = '1;
  logic [NCH-1:0] gate_en, short_flags, open_flags;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  bit [NCH-1:0] m_gate, m_sst, m_ost, m_cs, m_co;
  int m_hold[NCH], m_hi[NCH], m_lo[NCH];
  string gate_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lsd_fault_supervisor #(
    .NCH(NCH), .SENSE_CYC(S), .REFRESH_CYC(R), .OPEN_CYC(O)
  ) dut (
    .clk(clk), .rst(rst), .por_active(por), .ovp_active(ovp),
    .gate_cmd(cmd), .drain_hi(drn), .status_rd(rd),
    .gate_en(gate_en), .short_flags(short_flags), .open_flags(open_flags)
  );

  task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: next state after the coming edge, from current inputs.
  task automatic model_step();
    bit [NCH-1:0] se, oe;
    se = '0; oe = '0;
    if (rst) begin
      m_gate = '0; m_sst = '0; m_ost = '0; m_cs = '0; m_co = '0;
      for (int i = 0; i < NCH; i++) begin m_hold[i] = 0; m_hi[i] = 0; m_lo[i] = 0; end
      gate_tag = "R1";
      return;
    end
    gate_tag = (por || ovp) ? "R3" : "R2";
    for (int i = 0; i < NCH; i++) begin
      if (por || ovp) begin
        m_gate[i] = 0; m_hold[i] = 0; m_hi[i] = 0; m_lo[i] = 0;
      end else begin
        bit g0;
        g0 = m_gate[i];
        if (!g0 && !cmd[i] && !drn[i]) begin
          if (m_lo[i] == O-1) oe[i] = 1; else m_lo[i]++;
        end else m_lo[i] = 0;
        if (g0) begin
          if (!cmd[i]) begin m_gate[i] = 0; m_hi[i] = 0; end
          else if (drn[i]) begin
            if (m_hi[i] == S-1) begin
              se[i] = 1; m_gate[i] = 0; m_hold[i] = R-1; m_hi[i] = 0;
            end else m_hi[i]++;
          end else m_hi[i] = 0;
        end else begin
          if (m_hold[i] > 0) begin m_hold[i]--; gate_tag = "R5"; end
          else if (cmd[i]) begin m_gate[i] = 1; m_hi[i] = 0; end
        end
      end
    end
    if (rd) begin
      m_cs = m_sst | se; m_co = m_ost | oe; m_sst = '0; m_ost = '0;
    end else begin
      m_sst |= se; m_ost |= oe;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(gate_tag, gate_en, m_gate);
    chk("R8", short_flags, m_cs);
    chk("R8", open_flags, m_co);
  endtask

  task automatic read_pulse();
    rd = 1'b1; tick(); rd = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0063));
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1
    chk("R1", gate_en, '0); chk("R1", short_flags, '0); chk("R1", open_flags, '0);

    // R2: command follows with one edge
    drn = 6'h3E; cmd = 6'h01; tick();
    chk("R2", gate_en, 6'h01);
    cmd = 6'h00; tick(); chk("R2", gate_en, 6'h00);
    cmd = 6'h01; tick(); chk("R2", gate_en, 6'h01);

    // R4: short run below sense time, then a full one
    drn[0] = 1'b1; repeat (S-1) tick();
    chk("R4", gate_en, 6'h01);
    drn[0] = 1'b0; tick();
    drn[0] = 1'b1; repeat (S-1) tick();
    chk("R4", gate_en, 6'h01);
    tick(); chk("R4", gate_en, 6'h00);

    // R5: exact refresh length then retry
    repeat (R-1) tick(); chk("R5", gate_en, 6'h00);
    tick(); chk("R5", gate_en, 6'h01);
    drn[0] = 1'b0;
    read_pulse(); chk("R8", short_flags, 6'h01); chk("R8", open_flags, 6'h00);
    read_pulse(); chk("R8", short_flags, 6'h00);

    // R6: command re-raised inside refresh is held back
    drn[0] = 1'b1; repeat (S) tick(); chk("R4", gate_en, 6'h00);
    cmd[0] = 1'b0; repeat (3) tick();
    cmd[0] = 1'b1; repeat (R-4) tick(); chk("R6", gate_en, 6'h00);
    tick(); chk("R6", gate_en, 6'h01);
    repeat (S) tick(); chk("R4", gate_en, 6'h00);
    cmd[0] = 1'b0; repeat (R+1) tick(); chk("R6", gate_en, 6'h00);
    read_pulse(); chk("R8", short_flags, 6'h01);

    // R7: open load sensing while commanded off
    drn[0] = 1'b0; repeat (O-1) tick();
    drn[0] = 1'b1; read_pulse(); chk("R7", open_flags, 6'h00);
    drn[0] = 1'b0; repeat (O) tick();
    drn[0] = 1'b1; read_pulse(); chk("R7", open_flags, 6'h01);

    // R3: supply conditions
    cmd = 6'h3F; drn = 6'h00; tick(); chk("R3", gate_en, 6'h3F);
    por = 1'b1; tick(); chk("R3", gate_en, 6'h00);
    repeat (3) tick(); chk("R3", gate_en, 6'h00);
    por = 1'b0; tick(); chk("R3", gate_en, 6'h3F);
    ovp = 1'b1; tick(); chk("R3", gate_en, 6'h00);
    cmd = 6'h00; repeat (O+2) tick();
    read_pulse(); chk("R3", open_flags, 6'h00);
    ovp = 1'b0; drn = 6'h3F; tick();

    // R9: neighbours unaffected
    read_pulse();
    cmd = 6'h0C; drn = 6'h3B; tick(); chk("R9", gate_en, 6'h0C);
    repeat (S) tick(); chk("R9", gate_en, 6'h04);
    read_pulse(); chk("R9", short_flags, 6'h08); chk("R9", open_flags, 6'h00);

    // Random phase against the model
    for (int c = 0; c < 6000; c++) begin
      for (int i = 0; i < NCH; i++) begin
        if ($urandom % 6 == 0) drn[i] = ~drn[i];
        if ($urandom % 40 == 0) cmd[i] = ~cmd[i];
      end
      por = ($urandom % 400 == 0);
      ovp = ($urandom % 500 == 0);
      rd  = ($urandom % 25 == 0);
      tick();
    end
    rd = 1'b0; por = 1'b0; ovp = 1'b0;
    read_pulse();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule